// File: doc/BRIEF.md
# Video Black-Level Clamp Controller

This block is the digital half of a black-level clamp loop for a three-channel video converter front end. It watches the luma code stream and the time-shared chroma code stream. While clamping is active it compares every accepted sample with the black target of its channel. It then drives a registered command for each channel to an external clamp current source. The command is charge-up when the code is below the target, charge-down when it is above, and hold when it is equal. Luma aims at code 16. Both chroma channels aim at mid-scale code 128, which is zero in signed chroma terms.

Clamping is active in two cases. The first is the start-up precharge, which lasts a programmable number of cycles after reset. During precharge the fast level is raised and decisions are taken without waiting for a clamp window. The second case is a clamp window whose request input has stayed high for a minimum number of consecutive cycles. A shorter request is treated as noise. While clamping is active, the block flags chroma data as invalid, because the clamp disturbs the converted chroma.

Both sample inputs are valid/ready streams. The block never applies back-pressure: both ready outputs stay high, and a sample counts as accepted in any cycle where its valid is high. On the chroma stream, a select tag routes each sample to the U decision (tag 0) or the V decision (tag 1).

Top module: `video_clamp_ctrl`

## Requirements
- R1: Command encoding is bit 0 = charge-up and bit 1 = charge-down, with 00 meaning hold; 11 never appears. While clamping is active, an accepted luma sample updates the luma command at the next clock edge: code < 16 gives charge-up, code > 16 gives charge-down, and code 16 gives hold.
- R2: While clamping is active, an accepted chroma sample with tag 0 updates only the U command, and one with tag 1 updates only the V command. The compare is against 128 with the same rule as R1, and the command of the other chroma channel is left as it was.
- R3: In any cycle where clamping is not active, all three commands become hold at the next clock edge, whether or not samples arrive.
- R4: A clamp window becomes qualified in the cycle after the clamp request has been sampled high on MIN_WIN (default 20) consecutive rising edges. It stays qualified until the request is sampled low. A request shorter than MIN_WIN cycles changes neither the commands nor the chroma-invalid flag.
- R5: The chroma-invalid output is high exactly when clamping is active, that is during precharge or a qualified window. It drops in the cycle after the request is sampled low, once precharge has ended.
- R6: The fast output is high from reset for PRE_CYCLES (default 256) clock edges and low forever after. While it is high, accepted samples are decided as in R1 and R2 with the clamp request low.
- R7: During active clamping, a command keeps its value in cycles without an accepted sample of its channel.
- R8: During reset all commands are hold, fast is high and chroma-invalid is high.
- R9: Both ready outputs are high at all times, so the block never back-pressures a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clp_req | input | 1 | Clamp window request, sampled each edge |
| y_valid | input | 1 | Luma sample valid |
| y_ready | output | 1 | Luma ready, always high |
| y_code | input | 8 | Luma offset-binary code |
| c_valid | input | 1 | Chroma sample valid |
| c_ready | output | 1 | Chroma ready, always high |
| c_sel | input | 1 | Chroma tag: 0 = U, 1 = V |
| c_code | input | 8 | Chroma offset-binary code |
| y_cmd | output | 2 | Luma clamp command |
| u_cmd | output | 2 | U clamp command |
| v_cmd | output | 2 | V clamp command |
| fast | output | 1 | Precharge fast-correction level |
| chroma_inv | output | 1 | Chroma data invalid while clamping |

## Verification
The bench drives a clamp request of 19 cycles with a luma sample far below target. A qualifier that is off by one would raise chroma-invalid or command charge-up. A request of exactly 20 cycles must open the window for a single cycle, which catches a threshold set one cycle too late. The bench sends codes at the target, one above it and one below it, on every channel, so a swapped target or an inverted comparison shows up as the wrong command. Chroma samples alternate their tags to expose routing to the wrong channel, and the bench samples the fast level at cycles 255 and 256 after reset. After both precharge and a window end, it checks that commands fall to hold one cycle later rather than freezing at their last value.

// File: rtl/vclamp_pkg.sv
package vclamp_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'b00,
    CMD_UP   = 2'b01,
    CMD_DN   = 2'b10
  } clamp_cmd_e;

  localparam int NUM_CH = 3;
  localparam int CH_Y   = 0;
  localparam int CH_U   = 1;
  localparam int CH_V   = 2;
endpackage

// File: rtl/vclamp_win_qual.sv
module vclamp_win_qual #(
  parameter int MIN_WIN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clp_req,
  output logic win
);
  localparam int CW = $clog2(MIN_WIN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_WIN);

  logic [CW-1:0] run_cnt;

  // saturating count of consecutive high samples of the request
  always_ff @(posedge clk) begin
    if (!rst_n)             run_cnt <= '0;
    else if (!clp_req)      run_cnt <= '0;
    else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
  end

  assign win = (run_cnt == LIMIT);
endmodule

// File: rtl/vclamp_precharge.sv
module vclamp_precharge #(
  parameter int PRE_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic fast
);
  localparam int PW = $clog2(PRE_CYCLES + 1);
  localparam logic [PW-1:0] END_CNT = PW'(PRE_CYCLES);

  logic [PW-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 pre_cnt <= '0;
    else if (pre_cnt != END_CNT) pre_cnt <= pre_cnt + 1'b1;
  end

  assign fast = (pre_cnt != END_CNT);
endmodule

// File: rtl/vclamp_decide.sv
module vclamp_decide
  import vclamp_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int TARGET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] code,
  output clamp_cmd_e        cmd
);
  localparam logic [CODE_W-1:0] TGT = CODE_W'(TARGET);

  clamp_cmd_e verdict;

  always_comb begin
    if (code < TGT)      verdict = CMD_UP;
    else if (code > TGT) verdict = CMD_DN;
    else                 verdict = CMD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cmd <= CMD_HOLD;
    else if (!active)   cmd <= CMD_HOLD;
    else if (smp_valid) cmd <= verdict;
  end
endmodule

// File: rtl/video_clamp_ctrl.sv
module video_clamp_ctrl
  import vclamp_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int Y_TARGET   = 16,
  parameter int C_TARGET   = 128,
  parameter int MIN_WIN    = 20,
  parameter int PRE_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clp_req,
  input  logic              y_valid,
  output logic              y_ready,
  input  logic [CODE_W-1:0] y_code,
  input  logic              c_valid,
  output logic              c_ready,
  input  logic              c_sel,
  input  logic [CODE_W-1:0] c_code,
  output logic [1:0]        y_cmd,
  output logic [1:0]        u_cmd,
  output logic [1:0]        v_cmd,
  output logic              fast,
  output logic              chroma_inv
);
  logic win;
  logic active;
  logic              ch_valid [NUM_CH];
  logic [CODE_W-1:0] ch_code  [NUM_CH];
  clamp_cmd_e        ch_cmd   [NUM_CH];

  vclamp_win_qual #(.MIN_WIN(MIN_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .clp_req(clp_req), .win(win)
  );

  vclamp_precharge #(.PRE_CYCLES(PRE_CYCLES)) u_pre (
    .clk(clk), .rst_n(rst_n), .fast(fast)
  );

  assign active     = win | fast;
  assign chroma_inv = active;
  assign y_ready    = 1'b1;
  assign c_ready    = 1'b1;

  // route the shared chroma stream by its tag
  assign ch_valid[CH_Y] = y_valid;
  assign ch_valid[CH_U] = c_valid & ~c_sel;
  assign ch_valid[CH_V] = c_valid &  c_sel;
  assign ch_code[CH_Y]  = y_code;
  assign ch_code[CH_U]  = c_code;
  assign ch_code[CH_V]  = c_code;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int TGT = (g == CH_Y) ? Y_TARGET : C_TARGET;
    vclamp_decide #(.CODE_W(CODE_W), .TARGET(TGT)) u_dec (
      .clk(clk), .rst_n(rst_n), .active(active),
      .smp_valid(ch_valid[g]), .code(ch_code[g]), .cmd(ch_cmd[g])
    );
  end

  assign y_cmd = ch_cmd[CH_Y];
  assign u_cmd = ch_cmd[CH_U];
  assign v_cmd = ch_cmd[CH_V];
endmodule

// File: rtl/video_clamp_ctrl_chk.sv
module video_clamp_ctrl_chk #(
  parameter int CODE_W   = 8,
  parameter int Y_TARGET = 16,
  parameter int MIN_WIN  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clp_req,
  input logic              y_valid,
  input logic [CODE_W-1:0] y_code,
  input logic              y_ready,
  input logic              c_ready,
  input logic [1:0]        y_cmd,
  input logic [1:0]        u_cmd,
  input logic [1:0]        v_cmd,
  input logic              fast,
  input logic              chroma_inv
);
  localparam int RW = $clog2(MIN_WIN + 1);
  logic [RW-1:0] seen_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                        seen_run <= '0;
    else if (!clp_req)                 seen_run <= '0;
    else if (seen_run != RW'(MIN_WIN)) seen_run <= seen_run + 1'b1;
  end

  // R1
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(y_cmd) <= 1 && $countones(u_cmd) <= 1 && $countones(v_cmd) <= 1);

  // R1
  luma_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chroma_inv && y_valid && y_code < CODE_W'(Y_TARGET)) |=> (y_cmd == 2'b01));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chroma_inv |=> (y_cmd == 2'b00 && u_cmd == 2'b00 && v_cmd == 2'b00));

  // R4
  short_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chroma_inv && !fast) |-> (seen_run == RW'(MIN_WIN)));

  // R5
  fast_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast |-> chroma_inv);

  // R6
  fast_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fast |=> !fast);

  // R9
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_ready && c_ready);
endmodule

bind video_clamp_ctrl video_clamp_ctrl_chk #(
  .CODE_W(CODE_W), .Y_TARGET(Y_TARGET), .MIN_WIN(MIN_WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clp_req(clp_req), .y_valid(y_valid),
  .y_code(y_code), .y_ready(y_ready), .c_ready(c_ready),
  .y_cmd(y_cmd), .u_cmd(u_cmd), .v_cmd(v_cmd),
  .fast(fast), .chroma_inv(chroma_inv)
);

// File: tb/video_clamp_ctrl_test.sv
`timescale 1ns/1ps
module video_clamp_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clp_req = 1'b0;
  logic       y_valid = 1'b0;
  logic       y_ready;
  logic [7:0] y_code = '0;
  logic       c_valid = 1'b0;
  logic       c_ready;
  logic       c_sel = 1'b0;
  logic [7:0] c_code = '0;
  logic [1:0] y_cmd, u_cmd, v_cmd;
  logic       fast, chroma_inv;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [1:0] HOLD = 2'b00, UP = 2'b01, DN = 2'b10;

  always #2 clk = ~clk;

  video_clamp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .clp_req(clp_req),
    .y_valid(y_valid), .y_ready(y_ready), .y_code(y_code),
    .c_valid(c_valid), .c_ready(c_ready), .c_sel(c_sel), .c_code(c_code),
    .y_cmd(y_cmd), .u_cmd(u_cmd), .v_cmd(v_cmd),
    .fast(fast), .chroma_inv(chroma_inv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
  endtask

  task automatic cmds(input string req, input logic [1:0] ey, input logic [1:0] eu, input logic [1:0] ev);
    chk(y_cmd == ey, {req, " y_cmd"}, y_cmd, ey);
    chk(u_cmd == eu, {req, " u_cmd"}, u_cmd, eu);
    chk(v_cmd == ev, {req, " v_cmd"}, v_cmd, ev);
  endtask

  task automatic idle_inputs();
    y_valid = 1'b0;
    c_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) step();
    cmds("R8", HOLD, HOLD, HOLD);
    chk(fast == 1'b1, "R8 fast", fast, 1);
    chk(chroma_inv == 1'b1, "R8 chroma_inv", chroma_inv, 1);
    chk(y_ready && c_ready, "R9 ready", y_ready & c_ready, 1);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic t_precharge();
    y_valid = 1'b1; y_code = 8'd5;
    c_valid = 1'b1; c_sel = 1'b1; c_code = 8'd200;
    step();
    cmds("R6", UP, HOLD, DN);
    chk(fast == 1'b1, "R6 fast", fast, 1);
    y_valid = 1'b0; c_sel = 1'b0; c_code = 8'd100;
    step();
    cmds("R2", UP, UP, DN);
    idle_inputs();
    while (cyc < 255) step();
    chk(fast == 1'b1, "R6 fast at 255", fast, 1);
    chk(chroma_inv == 1'b1, "R5 inv at 255", chroma_inv, 1);
    cmds("R7", UP, UP, DN);
    step();
    chk(fast == 1'b0, "R6 fast at 256", fast, 0);
    chk(chroma_inv == 1'b0, "R5 inv after precharge", chroma_inv, 0);
    step();
    cmds("R3", HOLD, HOLD, HOLD);
    chk(fast == 1'b0, "R6 fast stays low", fast, 0);
  endtask

  task automatic t_short_pulse();
    clp_req = 1'b1; y_valid = 1'b1; y_code = 8'd3;
    for (int i = 0; i < 19; i++) begin
      step();
      chk(chroma_inv == 1'b0, "R4 short inv", chroma_inv, 0);
      chk(y_cmd == HOLD, "R4 short y_cmd", y_cmd, HOLD);
    end
    clp_req = 1'b0; y_valid = 1'b0;
    step();
    step();
    cmds("R4", HOLD, HOLD, HOLD);
  endtask

  task automatic t_exact_pulse();
    clp_req = 1'b1;
    for (int i = 0; i < 19; i++) step();
    chk(chroma_inv == 1'b0, "R4 inv at 19", chroma_inv, 0);
    step();
    chk(chroma_inv == 1'b1, "R4 inv at 20", chroma_inv, 1);
    clp_req = 1'b0;
    step();
    chk(chroma_inv == 1'b0, "R5 inv after drop", chroma_inv, 0);
    step();
  endtask

  task automatic t_window();
    clp_req = 1'b1;
    for (int i = 0; i < 20; i++) step();
    chk(chroma_inv == 1'b1, "R5 inv in window", chroma_inv, 1);
    cmds("R3", HOLD, HOLD, HOLD);
    y_valid = 1'b1; y_code = 8'd16; step();
    chk(y_cmd == HOLD, "R1 y=16", y_cmd, HOLD);
    y_code = 8'd17; step();
    chk(y_cmd == DN, "R1 y=17", y_cmd, DN);
    y_code = 8'd15; step();
    chk(y_cmd == UP, "R1 y=15", y_cmd, UP);
    y_valid = 1'b0;
    repeat (3) step();
    chk(y_cmd == UP, "R7 y kept", y_cmd, UP);
    c_valid = 1'b1; c_sel = 1'b0; c_code = 8'd127; step();
    cmds("R2 u=127", UP, UP, HOLD);
    c_sel = 1'b1; c_code = 8'd129; step();
    cmds("R2 v=129", UP, UP, DN);
    c_sel = 1'b0; c_code = 8'd128; step();
    cmds("R2 u=128", UP, HOLD, DN);
    c_sel = 1'b1; c_code = 8'd0; y_valid = 1'b1; y_code = 8'd255; step();
    cmds("R2 v=0", DN, HOLD, UP);
    idle_inputs();
    chk(y_ready && c_ready, "R9 ready in window", y_ready & c_ready, 1);
    clp_req = 1'b0;
    step();
    chk(chroma_inv == 1'b0, "R5 inv at exit", chroma_inv, 0);
    cmds("R7 at exit", DN, HOLD, UP);
    y_valid = 1'b1; y_code = 8'd0;
    step();
    cmds("R3 after exit", HOLD, HOLD, HOLD);
    y_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_precharge();
    t_short_pulse();
    t_exact_pulse();
    t_window();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule